// File: doc/BRIEF.md
# PWM-Synchronised Third-Order Sinc Sampler

This block turns the one-bit stream of a sigma-delta modulator into multi-bit current samples that line up with a PWM period. A chain of three integrators runs on every modulator bit. A chain of three differencing stages runs only when the block decimates, so the result is a third-order sinc filter with a selectable oversampling ratio. The modulator clock is an ordinary input. Its rising edges are found inside the system clock domain and act as the bit-sampling enable.

Decimation does not run freely. A local timer counts system clocks and restarts on every period-end sync pulse. When the timer equals a programmed trigger offset, the block runs a burst of four decimations, spaced one sample time (OSR modulator edges) apart. The first three decimations fill the differencing history. The fourth decimation gives a settled sample, which is presented with a one-clock valid strobe. A mode input allows a second trigger offset in the same period, and a slot output reports which trigger produced the sample.

Top module: `pwm_sinc_sampler`

## Requirements
- R1: While reset is asserted and after reset until a trigger burst completes, `sampleValid` is 0 and `sampleOut` is 0.
- R2: `osrSel` codes 0, 1, 2, 3 and 4 select OSR 16, 32, 64, 128 and 256. Codes 5 to 7 select OSR 64. A constant all-ones stream then settles to OSR³.
- R3: For a periodic bit pattern whose period divides the OSR, and which is stable across the burst, the reported sample equals OSR³ × (fraction of ones in the pattern).
- R4: A cycle with `syncPulse` high sets the timer to 0. The timer then advances by one per system clock and saturates at its maximum. A burst arms in the cycle where the timer equals a trigger offset.
- R5: An armed burst decimates on the first modulator edge after arming and then on every OSR-th modulator edge. On the fourth decimation, `sampleValid` is high for exactly one clock, in the clock that follows that decimation.
- R6: With `dualMode` = 0, only `trigOffsetA` arms bursts. `trigOffsetB` has no effect.
- R7: With `dualMode` = 1, both offsets arm bursts. `sampleSlot` is 0 for a sample armed by offset A and 1 for one armed by offset B. When both offsets are equal, offset A takes precedence.
- R8: A `syncPulse` during a burst aborts the burst, and that burst produces no valid sample.
- R9: A trigger offset match while a burst is running is ignored.
- R10: `modData` is taken only in the system clock where `modClk` is first seen high. Changes to `modData` at any other time do not affect the sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| modClk | input | 1 | Modulator bit clock, sampled in the system clock domain |
| modData | input | 1 | Modulator bit stream |
| syncPulse | input | 1 | Period-end pulse; clears the timer and aborts a burst |
| osrSel | input | 3 | Oversampling ratio code |
| dualMode | input | 1 | 0: one trigger per period, 1: two triggers per period |
| trigOffsetA | input | 16 | First trigger offset in system clocks after sync |
| trigOffsetB | input | 16 | Second trigger offset, used only in dual mode |
| sampleOut | output | 25 | Settled sinc sample (unsigned, up to OSR³) |
| sampleValid | output | 1 | One-clock strobe marking a new sample |
| sampleSlot | output | 1 | Trigger that produced the sample (0 = A, 1 = B) |

## Verification
The assertions check properties that must hold on every cycle. The valid strobe is never wider than one clock. A valid strobe follows only a final decimation. Sync always clears the timer and ends any burst. The integrators and the edge counter hold their values between modulator edges. The sample values, the arming of bursts by the right offset, the slot labels, the aborted bursts and the insensitivity to data glitches depend on whole periods of stimulus. Only the bench's scenarios can show these, using a behavioural timing model and an expected value derived from pattern density.

// File: rtl/pss_pkg.sv
package pss_pkg;
  // Strobes from burst control to the sinc datapath
  typedef struct packed {
    logic dec;   // decimate: capture differencing history this cycle
    logic last;  // final decimation of the burst: publish result
  } pss_strobe_t;
endpackage

// File: rtl/pss_modin.sv
module pss_modin (
  input  logic clk,
  input  logic rstN,
  input  logic modClk,
  input  logic modData,
  output logic modEdge,
  output logic modBit
);
  logic modClkQ;

  always_ff @(posedge clk) begin
    if (!rstN) modClkQ <= 1'b0;
    else       modClkQ <= modClk;
  end

  // First system clock in which the modulator clock is seen high
  assign modEdge = modClk & ~modClkQ;
  assign modBit  = modData;
endmodule

// File: rtl/pss_control.sv
module pss_control
  import pss_pkg::*;
#(
  parameter int TIMER_W      = 16,
  parameter int SEL_W        = 3,
  parameter int MIN_OSR_LOG2 = 4,
  parameter int MAX_OSR_LOG2 = 8,
  parameter int DEF_OSR_LOG2 = 6,
  parameter int SETTLE_N     = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               syncPulse,
  input  logic               modEdge,
  input  logic [SEL_W-1:0]   osrSel,
  input  logic               dualMode,
  input  logic [TIMER_W-1:0] trigOffsetA,
  input  logic [TIMER_W-1:0] trigOffsetB,
  output pss_strobe_t        strobe,
  output logic               burstSlot
);
  localparam int CNT_W    = MAX_OSR_LOG2;
  localparam int OSR_W    = MAX_OSR_LOG2 + 1;
  localparam int NUM_W    = (SETTLE_N > 2) ? $clog2(SETTLE_N) : 1;
  localparam int MAX_CODE = MAX_OSR_LOG2 - MIN_OSR_LOG2;
  localparam logic [TIMER_W-1:0] TIMER_MAX = '1;

  logic [TIMER_W-1:0] timerQ;
  logic               burstActive;
  logic [CNT_W-1:0]   edgeCnt;
  logic [NUM_W-1:0]   sampleNo;
  logic [OSR_W-1:0]   osrVal;
  logic [CNT_W-1:0]   edgeLoad;
  logic               hitA, hitB, trigHit;

  always_comb begin
    if (osrSel <= SEL_W'(MAX_CODE))
      osrVal = OSR_W'(1) << (32'(osrSel) + MIN_OSR_LOG2);
    else
      osrVal = OSR_W'(1) << DEF_OSR_LOG2;
    edgeLoad = CNT_W'(osrVal - OSR_W'(1));
  end

  assign hitA    = (timerQ == trigOffsetA);
  assign hitB    = dualMode && (timerQ == trigOffsetB);
  assign trigHit = !syncPulse && !burstActive && (hitA || hitB);

  assign strobe.dec  = burstActive && modEdge && !syncPulse && (edgeCnt == '0);
  assign strobe.last = strobe.dec && (sampleNo == NUM_W'(SETTLE_N - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerQ <= '0;
    end else if (syncPulse) begin
      timerQ <= '0;
    end else if (timerQ != TIMER_MAX) begin
      timerQ <= timerQ + TIMER_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstActive <= 1'b0;
      edgeCnt     <= '0;
      sampleNo    <= '0;
      burstSlot   <= 1'b0;
    end else if (syncPulse) begin
      burstActive <= 1'b0;
    end else if (trigHit) begin
      burstActive <= 1'b1;
      edgeCnt     <= '0;
      sampleNo    <= '0;
      burstSlot   <= !hitA;
    end else if (burstActive && modEdge) begin
      if (edgeCnt == '0) begin
        edgeCnt  <= edgeLoad;
        sampleNo <= sampleNo + NUM_W'(1);
        if (strobe.last) burstActive <= 1'b0;
      end else begin
        edgeCnt <= edgeCnt - CNT_W'(1);
      end
    end
  end

  // R4: the timer restarts from zero after every sync
  assert_sync_clears_timer_R4: assert property (@(posedge clk) disable iff (!rstN)
    syncPulse |=> (timerQ == '0));

  // R8: a sync always ends a running burst
  assert_sync_abort_R8: assert property (@(posedge clk) disable iff (!rstN)
    syncPulse |=> !burstActive);

  // R5: sample spacing counts only modulator edges
  assert_count_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (burstActive && !modEdge && !syncPulse) |=> $stable(edgeCnt));
endmodule

// File: rtl/pss_datapath.sv
module pss_datapath
  import pss_pkg::*;
#(
  parameter int ORDER = 3,
  parameter int ACC_W = 25
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modEdge,
  input  logic             modBit,
  input  pss_strobe_t      strobe,
  output logic [ACC_W-1:0] sampleOut,
  output logic             sampleValid
);
  logic [ACC_W-1:0] integ   [ORDER];
  logic [ACC_W-1:0] combIn  [ORDER+1];
  logic [ACC_W-1:0] combHist[ORDER];

  // Integrators: advance on each modulator bit, wrap modulo 2^ACC_W
  for (genvar g = 0; g < ORDER; g++) begin : g_integ
    logic [ACC_W-1:0] addend;
    if (g == 0) begin : g_first
      assign addend = {{(ACC_W-1){1'b0}}, modBit};
    end else begin : g_next
      assign addend = integ[g-1];
    end
    always_ff @(posedge clk) begin
      if (!rstN)        integ[g] <= '0;
      else if (modEdge) integ[g] <= integ[g] + addend;
    end
  end

  // Differencing stages: history captured only on decimation
  assign combIn[0] = integ[ORDER-1];
  for (genvar g = 0; g < ORDER; g++) begin : g_comb
    assign combIn[g+1] = combIn[g] - combHist[g];
    always_ff @(posedge clk) begin
      if (!rstN)           combHist[g] <= '0;
      else if (strobe.dec) combHist[g] <= combIn[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleOut   <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= strobe.last;
      if (strobe.last) sampleOut <= combIn[ORDER];
    end
  end

  // R5: the result strobe is a single clock wide
  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  // R5: a result appears only after a final decimation
  assert_valid_after_last_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sampleValid) |-> $past(strobe.last));

  // R10: the first integrator moves only on a modulator edge
  assert_integ_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !modEdge |=> $stable(integ[0]));
endmodule

// File: rtl/pwm_sinc_sampler.sv
module pwm_sinc_sampler
  import pss_pkg::*;
#(
  parameter int TIMER_W      = 16,
  parameter int SEL_W        = 3,
  parameter int MIN_OSR_LOG2 = 4,
  parameter int MAX_OSR_LOG2 = 8,
  parameter int DEF_OSR_LOG2 = 6,
  parameter int ORDER        = 3,
  parameter int SETTLE_N     = 4,
  localparam int ACC_W       = 1 + ORDER * MAX_OSR_LOG2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modClk,
  input  logic               modData,
  input  logic               syncPulse,
  input  logic [SEL_W-1:0]   osrSel,
  input  logic               dualMode,
  input  logic [TIMER_W-1:0] trigOffsetA,
  input  logic [TIMER_W-1:0] trigOffsetB,
  output logic [ACC_W-1:0]   sampleOut,
  output logic               sampleValid,
  output logic               sampleSlot
);
  logic        modEdge;
  logic        modBit;
  pss_strobe_t strobe;

  pss_modin u_modin (
    .clk     (clk),
    .rstN    (rstN),
    .modClk  (modClk),
    .modData (modData),
    .modEdge (modEdge),
    .modBit  (modBit)
  );

  pss_control #(
    .TIMER_W      (TIMER_W),
    .SEL_W        (SEL_W),
    .MIN_OSR_LOG2 (MIN_OSR_LOG2),
    .MAX_OSR_LOG2 (MAX_OSR_LOG2),
    .DEF_OSR_LOG2 (DEF_OSR_LOG2),
    .SETTLE_N     (SETTLE_N)
  ) u_control (
    .clk         (clk),
    .rstN        (rstN),
    .syncPulse   (syncPulse),
    .modEdge     (modEdge),
    .osrSel      (osrSel),
    .dualMode    (dualMode),
    .trigOffsetA (trigOffsetA),
    .trigOffsetB (trigOffsetB),
    .strobe      (strobe),
    .burstSlot   (sampleSlot)
  );

  pss_datapath #(
    .ORDER (ORDER),
    .ACC_W (ACC_W)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .modEdge     (modEdge),
    .modBit      (modBit),
    .strobe      (strobe),
    .sampleOut   (sampleOut),
    .sampleValid (sampleValid)
  );
endmodule

// File: tb/pwm_sinc_sampler_bench.sv
module pwm_sinc_sampler_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modClk = 1'b0;
  logic        modData = 1'b0;
  logic        syncPulse = 1'b0;
  logic [2:0]  osrSel = 3'd2;
  logic        dualMode = 1'b0;
  logic [15:0] trigOffsetA = 16'd40;
  logic [15:0] trigOffsetB = 16'd0;
  logic [24:0] sampleOut;
  logic        sampleValid;
  logic        sampleSlot;

  always #2 clk = ~clk;

  pwm_sinc_sampler u_pwm_sinc_sampler (
    .clk(clk), .rstN(rstN), .modClk(modClk), .modData(modData),
    .syncPulse(syncPulse), .osrSel(osrSel), .dualMode(dualMode),
    .trigOffsetA(trigOffsetA), .trigOffsetB(trigOffsetB),
    .sampleOut(sampleOut), .sampleValid(sampleValid), .sampleSlot(sampleSlot)
  );

  int errors = 0;
  int checks = 0;
  int pulses = 0;
  bit done = 0;

  // Modulator stimulus: bit clock of four system clocks, data set with the rising edge
  logic [15:0] pat = 16'hFFFF;
  bit glitch = 0;
  int bitIdx = 0;
  int negCnt = 0;
  always @(negedge clk) begin
    case (negCnt % 4)
      0: begin modClk = 1'b1; bitIdx = (bitIdx + 1) % 16; modData = pat[bitIdx]; end
      1: if (glitch) modData = ~pat[bitIdx];
      2: modClk = 1'b0;
      default: ;
    endcase
    negCnt++;
  end

  function automatic longint osrOf(input logic [2:0] s);
    case (s)
      3'd0: return 16;
      3'd1: return 32;
      3'd2: return 64;
      3'd3: return 128;
      3'd4: return 256;
      default: return 64;
    endcase
  endfunction

  // Behavioural timing model, evaluated with the inputs present at each rising edge
  int     tmr = 0;
  bit     act = 0;
  int     cnt = 0;
  int     nDone = 0;
  bit     slotM = 0;
  bit     mPrev = 0;
  bit     expValid = 0;
  bit     expSlot = 0;
  longint expVal = 0;
  always @(posedge clk) begin
    bit e;
    e = modClk && !mPrev;
    mPrev = modClk;
    expValid = 0;
    if (!rstN) begin
      tmr = 0; act = 0; mPrev = 0;
    end else if (syncPulse) begin
      tmr = 0; act = 0;
    end else begin
      if (act) begin
        if (e) begin
          if (cnt == 0) begin
            nDone++;
            cnt = int'(osrOf(osrSel)) - 1;
            if (nDone == 4) begin
              expValid = 1;
              expSlot = slotM;
              expVal = osrOf(osrSel) ** 3 * $countones(pat) / 16;
              act = 0;
            end
          end else cnt--;
        end
      end else if (tmr == int'(trigOffsetA) || (dualMode && tmr == int'(trigOffsetB))) begin
        act = 1; cnt = 0; nDone = 0;
        slotM = (tmr != int'(trigOffsetA));
      end
      if (tmr < 65535) tmr++;
    end
  end

  // Per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (sampleValid !== expValid) begin
        errors++;
        $display("FAIL R5 valid timing: got %0b expected %0b at %0t", sampleValid, expValid, $time);
      end
      if (expValid) begin
        checks += 2;
        if (longint'(sampleOut) != expVal) begin
          errors++;
          $display("FAIL R3 sample value: got %0d expected %0d (osrSel %0d)", sampleOut, expVal, osrSel);
        end
        if (sampleSlot !== expSlot) begin
          errors++;
          $display("FAIL R7 slot: got %0b expected %0b", sampleSlot, expSlot);
        end
      end
      if (sampleValid) pulses++;
    end
  end

  task automatic check(input bit ok, input string tag, input longint got, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // One scenario: settings applied with the first sync, then whole periods
  task automatic runScenario(input logic [2:0] sel, input bit dual, input int offA,
                             input int offB, input logic [15:0] p, input bit gl,
                             input int periodLen, input int nPeriods,
                             input int expPulses, input string tag);
    int startPulses;
    startPulses = pulses;
    for (int k = 0; k < nPeriods; k++) begin
      @(negedge clk);
      syncPulse = 1'b1;
      if (k == 0) begin
        osrSel = sel; dualMode = dual;
        trigOffsetA = 16'(offA); trigOffsetB = 16'(offB);
        pat = p; glitch = gl;
      end
      @(negedge clk);
      syncPulse = 1'b0;
      repeat (periodLen - 2) @(negedge clk);
    end
    check(pulses - startPulses == expPulses, tag, pulses - startPulses, expPulses);
  endtask

  initial begin
    // R1: reset state and idle outputs before any burst
    repeat (5) @(negedge clk);
    check(sampleValid === 1'b0, "R1 valid in reset", sampleValid, 0);
    check(sampleOut === 25'd0, "R1 sample in reset", sampleOut, 0);
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    check(sampleValid === 1'b0 && pulses == 0, "R1 idle after reset", pulses, 0);
    check(sampleOut === 25'd0, "R1 sample idle", sampleOut, 0);

    // R2 R4: OSR 64, all ones, single trigger
    runScenario(3'd2, 0, 40, 0, 16'hFFFF, 0, 16*64 + 120, 3, 3, "R4 bursts per period OSR64");
    check(sampleOut == 25'd262144, "R2 settled ones OSR64", sampleOut, 262144);
    // R3: densities at several ratios
    runScenario(3'd0, 0, 36, 0, 16'h1111, 0, 16*16 + 120, 3, 3, "R3 OSR16 quarter density");
    check(sampleOut == 25'd1024, "R3 OSR16 value", sampleOut, 1024);
    runScenario(3'd1, 0, 50, 0, 16'h5555, 0, 16*32 + 120, 3, 3, "R3 OSR32 half density");
    runScenario(3'd3, 0, 44, 0, 16'h2A49, 0, 16*128 + 120, 2, 2, "R3 OSR128 6/16 density");
    check(sampleOut == 25'd786432, "R3 OSR128 value", sampleOut, 786432);
    runScenario(3'd4, 0, 40, 0, 16'h0000, 0, 16*256 + 120, 2, 2, "R3 OSR256 zeros");
    check(sampleOut == 25'd0, "R3 OSR256 zero value", sampleOut, 0);
    runScenario(3'd4, 0, 40, 0, 16'hFFFF, 0, 16*256 + 120, 2, 2, "R2 OSR256 ones");
    check(sampleOut == 25'd16777216, "R2 OSR256 full scale", sampleOut, 16777216);
    // R2: out-of-range code falls back to 64
    runScenario(3'd7, 0, 40, 0, 16'h00FF, 0, 16*64 + 120, 2, 2, "R2 code 7 bursts");
    check(sampleOut == 25'd131072, "R2 code 7 selects 64", sampleOut, 131072);
    // R6: offset B ignored in single mode
    runScenario(3'd1, 0, 40, 40 + 16*32 + 40, 16'h3333, 0, 2*16*32 + 200, 3, 3, "R6 single mode ignores B");
    // R7: dual mode, two samples per period with slot labels
    runScenario(3'd1, 1, 40, 40 + 16*32 + 40, 16'h0F0F, 0, 2*16*32 + 200, 3, 6, "R7 dual mode two per period");
    check(sampleSlot === 1'b1, "R7 last slot is B", sampleSlot, 1);
    // R9: second offset inside a running burst
    runScenario(3'd1, 1, 40, 140, 16'h0F0F, 0, 16*32 + 200, 3, 3, "R9 match during burst ignored");
    // R8: sync arrives before the burst completes
    runScenario(3'd2, 0, 40, 0, 16'hFFFF, 0, 240, 4, 0, "R8 aborted bursts");
    // R10: data glitches away from the modulator edge
    runScenario(3'd1, 0, 48, 0, 16'h3333, 1, 16*32 + 120, 3, 3, "R10 glitch-immune bursts");
    check(sampleOut == 25'd16384, "R10 value with glitches", sampleOut, 16384);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule